// File: doc/BRIEF.md
# Configurable Bidirectional Port with Power-Mode Controls

This block is one 8-bit memory-mapped I/O port. A pin gets its mode from the pair of bits at its position in two software registers. The configuration bit chooses between input and output. The data bit then chooses a weak pull-up for an input, or the driven level for an output. A third, read-only address returns the pin levels after a two-flop synchronizer. The block never touches the pads directly. It drives per-pin output-enable, output-value and pull-up-enable lines that a pad ring turns into real drivers.

A parameter selects a control variant of the port. In that variant the top two pins are inputs only, and their register bits take on other jobs. The top two data bits request halt and idle as one-cycle pulses and are never stored. The top two configuration bits select the alternate serial-clock phase and enable a clock start-up delay. A rising edge on the top pin raises a wake pulse, unless the crystal option is selected. When the watchdog option is enabled, pin 1 carries the watchdog output with a weak pull-up.

Top module: `gpio_cfg_port`

## Requirements
- R1: After reset, the configuration and data registers are zero. Every pad output-enable, output-value and pull-up line is low, and halt_req, idle_req, alt_sk_phase, clk_delay_en and wake_pulse are low.
- R2: For an ordinary pin with configuration bit c and data bit d: pad_oe = c, pad_out = c AND d, and pad_pu = (NOT c) AND d. So (0,0) is a high-impedance input, (0,1) an input with pull-up, (1,0) drives low, and (1,1) drives high.
- R3: Address 0 is the configuration register (read/write). Address 1 is the data register (read/write). Address 2 returns the synchronized pins and ignores writes. Address 3 reads zero. A write takes effect at the clock edge where bus_sel and bus_wr are both high.
- R4: A level placed on pin_in appears at address 2 after exactly two rising clock edges, and not after one.
- R5: In the control variant, a data write with bit 7 set raises halt_req for exactly the one cycle that follows the write edge. A data write with bit 6 set does the same for idle_req.
- R6: In the control variant, data bits 7 and 6 always read as zero. In the plain variant, all eight data bits read back as written.
- R7: In the control variant, alt_sk_phase follows configuration bit 6 and clk_delay_en follows configuration bit 7.
- R8: In the control variant, pins 6 and 7 always have pad_oe, pad_out and pad_pu low, whatever the register contents.
- R9: In the control variant, while wdog_en is high, pin 1 ignores its register bits. Its pad_pu is 1, pad_out is 0 and pad_oe = NOT wdog_out. While wdog_en is low, pin 1 follows R2.
- R10: In the control variant, with xtal_sel low, a low-to-high change on pin_in[7] gives one wake_pulse cycle, starting at the second rising edge after the change. With xtal_sel high, no pulse is produced.
- R11: In the plain variant, all eight pins follow R2. halt_req, idle_req, alt_sk_phase, clk_delay_en and wake_pulse stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| pin_in | input | 8 | Pad input levels, asynchronous |
| wdog_en | input | 1 | Watchdog option: pin 1 is taken over |
| wdog_out | input | 1 | Watchdog output level for pin 1 |
| xtal_sel | input | 1 | Crystal option selected: wake edge disabled |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |
| pad_pu | output | 8 | Per-pin weak pull-up enable |
| halt_req | output | 1 | One-cycle halt request |
| idle_req | output | 1 | One-cycle idle request |
| alt_sk_phase | output | 1 | Alternate serial-clock phase select |
| clk_delay_en | output | 1 | Start-up delay after halt enabled |
| wake_pulse | output | 1 | One-cycle wake from halt |

## Verification
The bench builds two copies of the block side by side on one bus and one set of pins. One has SPECIAL=1 and one has SPECIAL=0, both with WIDTH=8. The control copy covers the masked data bits, the pulse requests, the watchdog takeover of pin 1 and the wake edge with and without the crystal option. The plain copy shows that the same register writes drive all eight pins as ordinary I/O and leave the control outputs quiet.

// File: rtl/gpio_cfg_port.sv
module gpio_cfg_port #(
  parameter int WIDTH   = 8,
  parameter bit SPECIAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pin_in,
  input  logic             wdog_en,
  input  logic             wdog_out,
  input  logic             xtal_sel,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_pu,
  output logic             halt_req,
  output logic             idle_req,
  output logic             alt_sk_phase,
  output logic             clk_delay_en,
  output logic             wake_pulse
);
  localparam logic [1:0] A_CFG = 2'd0;
  localparam logic [1:0] A_DAT = 2'd1;
  localparam logic [1:0] A_PIN = 2'd2;
  localparam int TOP = WIDTH - 1;
  localparam int NXT = WIDTH - 2;
  localparam int WD_PIN = 1;
  localparam logic [WIDTH-1:0] CTRL_MASK = {2'b11, {(WIDTH-2){1'b0}}};
  localparam logic [WIDTH-1:0] DAT_KEEP = SPECIAL ? ~CTRL_MASK : '1;

  logic [WIDTH-1:0] cfg_q, dat_q, sync1_q, sync2_q;
  logic wake_prev_q, halt_q, idle_q;

  wire wr_cfg = bus_sel & bus_wr & (bus_addr == A_CFG);
  wire wr_dat = bus_sel & bus_wr & (bus_addr == A_DAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q       <= '0;
      dat_q       <= '0;
      sync1_q     <= '0;
      sync2_q     <= '0;
      wake_prev_q <= 1'b0;
      halt_q      <= 1'b0;
      idle_q      <= 1'b0;
    end else begin
      if (wr_cfg) cfg_q <= bus_wdata;
      if (wr_dat) dat_q <= bus_wdata & DAT_KEEP;
      sync1_q     <= pin_in;
      sync2_q     <= sync1_q;
      wake_prev_q <= sync2_q[TOP];
      halt_q      <= SPECIAL & wr_dat & bus_wdata[TOP];
      idle_q      <= SPECIAL & wr_dat & bus_wdata[NXT];
    end
  end

  always_comb begin
    case (bus_addr)
      A_CFG:   bus_rdata = cfg_q;
      A_DAT:   bus_rdata = dat_q;
      A_PIN:   bus_rdata = sync2_q;
      default: bus_rdata = '0;
    endcase
  end

  wire [WIDTH-1:0] oe_n  = cfg_q;
  wire [WIDTH-1:0] out_n = cfg_q & dat_q;
  wire [WIDTH-1:0] pu_n  = ~cfg_q & dat_q;

  assign halt_req = halt_q;
  assign idle_req = idle_q;

  generate
    if (SPECIAL) begin : g_ctrl
      always_comb begin
        pad_oe  = oe_n  & ~CTRL_MASK;
        pad_out = out_n & ~CTRL_MASK;
        pad_pu  = pu_n  & ~CTRL_MASK;
        if (wdog_en) begin
          pad_oe[WD_PIN]  = ~wdog_out;
          pad_out[WD_PIN] = 1'b0;
          pad_pu[WD_PIN]  = 1'b1;
        end
      end
      assign alt_sk_phase = cfg_q[NXT];
      assign clk_delay_en = cfg_q[TOP];
      assign wake_pulse   = sync2_q[TOP] & ~wake_prev_q & ~xtal_sel;
    end else begin : g_plain
      assign pad_oe       = oe_n;
      assign pad_out      = out_n;
      assign pad_pu       = pu_n;
      assign alt_sk_phase = 1'b0;
      assign clk_delay_en = 1'b0;
      assign wake_pulse   = 1'b0;
    end
  endgenerate
endmodule

module gpio_cfg_port_chk #(
  parameter int WIDTH   = 8,
  parameter bit SPECIAL = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic [WIDTH-1:0] bus_wdata,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_pu,
  input logic             wdog_en,
  input logic             halt_req,
  input logic             idle_req,
  input logic             wake_pulse
);
  p_drive_consistent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & ~pad_oe) == '0));
  p_halt_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_req) |-> $past(bus_sel && bus_wr && bus_addr == 2'd1 && bus_wdata[WIDTH-1]));
  p_idle_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_req) |-> $past(bus_sel && bus_wr && bus_addr == 2'd1 && bus_wdata[WIDTH-2]));
  p_top_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    SPECIAL |-> (pad_oe[WIDTH-1:WIDTH-2] == 2'b00 && pad_pu[WIDTH-1:WIDTH-2] == 2'b00));
  p_wdog_pullup_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (SPECIAL && wdog_en) |-> (pad_pu[1] && !pad_out[1]));
  p_wake_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);
  p_plain_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !SPECIAL |-> (!halt_req && !idle_req && !wake_pulse));
endmodule

bind gpio_cfg_port gpio_cfg_port_chk #(.WIDTH(WIDTH), .SPECIAL(SPECIAL)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
  .wdog_en(wdog_en), .halt_req(halt_req), .idle_req(idle_req), .wake_pulse(wake_pulse)
);

// File: tb/test_gpio_cfg_port.sv
module test_gpio_cfg_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0, pin_in = 8'd0;
  logic wdog_en = 1'b0, wdog_out = 1'b1, xtal_sel = 1'b0;

  logic [7:0] rd_s, oe_s, out_s, pu_s, rd_p, oe_p, out_p, pu_p;
  logic halt_s, idle_s, alt_s, dly_s, wake_s;
  logic halt_p, idle_p, alt_p, dly_p, wake_p;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] cfg_m = 8'd0, dat_m = 8'd0, dat_pm = 8'd0;

  always #4 clk = ~clk;

  gpio_cfg_port #(.WIDTH(8), .SPECIAL(1'b1)) i_gpio_cfg_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_s), .pin_in(pin_in), .wdog_en(wdog_en),
    .wdog_out(wdog_out), .xtal_sel(xtal_sel), .pad_oe(oe_s), .pad_out(out_s), .pad_pu(pu_s),
    .halt_req(halt_s), .idle_req(idle_s), .alt_sk_phase(alt_s), .clk_delay_en(dly_s),
    .wake_pulse(wake_s));

  gpio_cfg_port #(.WIDTH(8), .SPECIAL(1'b0)) i_gpio_cfg_port_plain (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_p), .pin_in(pin_in), .wdog_en(wdog_en),
    .wdog_out(wdog_out), .xtal_sel(xtal_sel), .pad_oe(oe_p), .pad_out(out_p), .pad_pu(pu_p),
    .halt_req(halt_p), .idle_req(idle_p), .alt_sk_phase(alt_p), .clk_delay_en(dly_p),
    .wake_pulse(wake_p));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] pads(input logic [7:0] c, input logic [7:0] d,
                                       input bit sp, input bit wen, input bit wo);
    logic [7:0] oe, o, pu;
    oe = c; o = c & d; pu = ~c & d;
    if (sp) begin
      oe[7:6] = 2'b00; o[7:6] = 2'b00; pu[7:6] = 2'b00;
      if (wen) begin oe[1] = ~wo; o[1] = 1'b0; pu[1] = 1'b1; end
    end
    return {oe, o, pu};
  endfunction

  task automatic check_pads(input string tag);
    chk({tag, " R2/R8/R9 ctrl pads"}, {8'd0, oe_s, out_s, pu_s}, {8'd0, pads(cfg_m, dat_m, 1'b1, wdog_en, wdog_out)});
    chk({tag, " R11 plain pads"}, {8'd0, oe_p, out_p, pu_p}, {8'd0, pads(cfg_m, dat_pm, 1'b0, 1'b0, 1'b0)});
  endtask

  // Drive at negedge, commit at posedge, return at the next negedge.
  task automatic wr(input logic [1:0] a, input logic [7:0] v);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    if (a == 2'd0) cfg_m = v;
    if (a == 2'd1) begin dat_m = v & 8'h3F; dat_pm = v; end
  endtask

  task automatic rd_both(input logic [1:0] a, output logic [7:0] s, output logic [7:0] p);
    bus_addr = a; #1; s = rd_s; p = rd_p;
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] s, p;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 pads after reset", {oe_s, out_s, pu_s, oe_p}, 32'd0);
    chk("R1 ctrl after reset", {halt_s, idle_s, alt_s, dly_s, wake_s}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_both(2'd0, s, p); chk("R1 cfg reset", s, 8'h00);
    rd_both(2'd1, s, p); chk("R1 data reset", s, 8'h00);

    // R2 all four modes across pins 0,2,3,4
    wr(2'd1, 8'b0001_0100);
    wr(2'd0, 8'b0001_1000);
    check_pads("modes");
    chk("R2 pin4 drive high", {oe_s[4], out_s[4], pu_s[4]}, 3'b110);
    chk("R2 pin3 drive low", {oe_s[3], out_s[3], pu_s[3]}, 3'b100);
    chk("R2 pin2 pullup", {oe_s[2], out_s[2], pu_s[2]}, 3'b001);
    chk("R2 pin0 hiz", {oe_s[0], out_s[0], pu_s[0]}, 3'b000);

    // R6 masking, R5 pulses
    wr(2'd1, 8'hFF);
    chk("R5 halt pulse", halt_s, 1'b1);
    chk("R5 idle pulse", idle_s, 1'b1);
    chk("R11 plain no halt", {halt_p, idle_p}, 2'b00);
    @(negedge clk);
    chk("R5 halt self-clears", {halt_s, idle_s}, 2'b00);
    rd_both(2'd1, s, p);
    chk("R6 ctrl data top bits read zero", s, 8'h3F);
    chk("R6 plain data read back", p, 8'hFF);
    wr(2'd1, 8'h40);
    chk("R5 idle only", {halt_s, idle_s}, 2'b01);

    // R7 / R8
    wr(2'd0, 8'hC0);
    chk("R7 alt phase and delay", {alt_s, dly_s}, 2'b11);
    chk("R11 plain ctrl quiet", {alt_p, dly_p}, 2'b00);
    chk("R8 top pins hiz", {oe_s[7:6], pu_s[7:6], out_s[7:6]}, 6'd0);
    wr(2'd0, 8'h40);
    chk("R7 alt phase only", {alt_s, dly_s}, 2'b10);

    // R3 read-only input and unused address
    pin_in = 8'h5A;
    repeat (3) @(negedge clk);
    wr(2'd2, 8'hFF);
    rd_both(2'd2, s, p); chk("R3 input ignores write", s, 8'h5A);
    rd_both(2'd0, s, p); chk("R3 cfg untouched by input write", s, 8'h40);
    rd_both(2'd3, s, p); chk("R3 addr3 zero", s, 8'h00);

    // R4 two-edge sync
    rd_both(2'd2, s, p);
    pin_in = 8'hA5;
    @(negedge clk); rd_both(2'd2, s, p); chk("R4 not after one edge", s, 8'h5A);
    @(negedge clk); rd_both(2'd2, s, p); chk("R4 after two edges", s, 8'hA5);

    // R10 wake
    pin_in = 8'h00; xtal_sel = 1'b0;
    repeat (3) @(negedge clk);
    pin_in[7] = 1'b1;
    @(negedge clk); chk("R10 no wake after one edge", wake_s, 1'b0);
    @(negedge clk); chk("R10 wake pulse", wake_s, 1'b1);
    chk("R11 plain no wake", wake_p, 1'b0);
    @(negedge clk); chk("R10 wake one cycle", wake_s, 1'b0);
    pin_in[7] = 1'b0; xtal_sel = 1'b1;
    repeat (3) @(negedge clk);
    pin_in[7] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R10 no wake with crystal", wake_s, 1'b0);
    xtal_sel = 1'b0;

    // R9 directed
    wr(2'd0, 8'h02); wr(2'd1, 8'h02);
    wdog_en = 1'b1; wdog_out = 1'b1; #1;
    chk("R9 wdog high released", {oe_s[1], out_s[1], pu_s[1]}, 3'b001);
    wdog_out = 1'b0; #1;
    chk("R9 wdog low drives", {oe_s[1], out_s[1], pu_s[1]}, 3'b101);
    wdog_en = 1'b0; #1;
    chk("R9 normal pin1 when off", {oe_s[1], out_s[1], pu_s[1]}, 3'b110);
    @(negedge clk);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0] a;
      logic [7:0] v;
      bit ehalt, eidle;
      a = 2'($urandom_range(0, 2));
      v = 8'($urandom);
      wdog_en = 1'($urandom); wdog_out = 1'($urandom);
      wr(a, v);
      ehalt = (a == 2'd1) && v[7];
      eidle = (a == 2'd1) && v[6];
      #1;
      check_pads("rand");
      chk("R5 rand halt/idle", {halt_s, idle_s}, {ehalt, eidle});
      chk("R7 rand ctrl", {alt_s, dly_s}, {cfg_m[6], cfg_m[7]});
      rd_both(2'd1, s, p);
      chk("R6 rand ctrl data", s, dat_m);
      chk("R6 rand plain data", p, dat_pm);
      rd_both(2'd0, s, p);
      chk("R3 rand cfg", {s, p}, {cfg_m, cfg_m});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule